// File: doc/BRIEF.md
# Button-stepped multichannel PWM generator

The block drives four pulse-width modulated outputs from one free-running 8-bit period counter that all channels share. Each channel keeps its own duty level as a step index from 0 to 10, where each step is a tenth of full scale. Each channel has a push-button input. A clean press moves that channel up by one step. A press at full scale returns the channel to zero.

Button inputs are asynchronous and may bounce. Each one passes through a two-flop synchronizer and a stability counter, and only then reaches an edge detector that emits a single pulse for each accepted press. A changed duty level does not reach the output comparator until the period counter wraps, so every PWM period is built from one compare value only. The current step index of every channel is visible on an output bus.

Top module: `pwm_step_bank`

## Requirements
- R1: After reset, every channel's step index is 0 and every PWM output is low. Channel k's 4-bit step index appears on duty_o[4k+3:4k].
- R2: An accepted press on button k raises only channel k's step index by one. The other channels keep their indices.
- R3: A press while a channel is at step 10 sets that channel to step 0.
- R4: Step i maps to compare value round(i*25.6). The values for steps 0 to 10 are 0, 26, 51, 77, 102, 128, 154, 179, 205, 230, 256.
- R5: One shared 8-bit counter sets a 256-cycle period for every channel. At count 0, every output whose compare value is nonzero goes high.
- R6: An output goes low when the count reaches its compare value and stays low until the next wrap. Each period therefore holds exactly as many high cycles as the compare value.
- R7: A compare value of 0 keeps the output low for the whole period. A compare value of 256 keeps it high for the whole period.
- R8: A button level counts only after it has differed from the accepted level for DEB_CNT consecutive cycles after synchronization. Pulses or bounces shorter than that cause no step.
- R9: A press held for any length gives exactly one step, produced on the accepted rising edge of the button. The release gives none.
- R10: A new compare value takes effect only at the start of the next period. Every high pulse in a period is complete and has the old or the new width, never a truncated or repeated fragment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_i | input | N_CH | Raw push-button levels, one per channel, active high |
| pwm_o | output | N_CH | PWM outputs, one per channel |
| duty_o | output | N_CH*STEP_W | Current step index of each channel (4 bits per channel by default) |

## Verification
Assertions check the following on every cycle: the step index stays in range, it moves only on a press pulse and by one step or a wrap to zero, press pulses never last longer than one cycle, the shadowed compare value changes only at a wrap, an output with a nonzero compare value rises at wrap, and a low output stays low until the wrap. Some behaviour only the bench scenarios can show: the exact number of high cycles per period at each step, the rejection of bounce bursts, and the single step from a long hold. The bench also presses a button right after a falling edge, where an immediate compare update would leave a short stray pulse, and shows that no such pulse appears.

// File: rtl/pwm_step_pkg.sv
package pwm_step_pkg;
  // round-half-up of step * 2^cnt_w / steps
  function automatic int unsigned step_to_cmp(int unsigned step, int unsigned steps,
                                              int unsigned cnt_w);
    return (((step << cnt_w) * 2) + steps) / (2 * steps);
  endfunction
endpackage

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
  parameter int unsigned DEB_CNT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic press_o
);
  localparam int unsigned DEB_W = $clog2(DEB_CNT + 1);

  logic [1:0]       sync_q;
  logic             stable_q;
  logic [DEB_W-1:0] cnt_q;
  logic             press_q;
  logic             accept;

  assign accept = (sync_q[1] != stable_q) && (cnt_q == DEB_W'(DEB_CNT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= '0;
      stable_q <= 1'b0;
      cnt_q    <= '0;
      press_q  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], btn_i};
      press_q <= accept && sync_q[1];
      if (sync_q[1] == stable_q) begin
        cnt_q <= '0;
      end else if (accept) begin
        stable_q <= sync_q[1];
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign press_o = press_q;

  // R9
  single_press_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |=> !press_o);

  // R8
  stable_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q[1] != stable_q) && (cnt_q != DEB_W'(DEB_CNT - 1)) |=> $stable(stable_q));
endmodule

// File: rtl/duty_stepper.sv
module duty_stepper #(
  parameter int unsigned STEPS  = 10,
  parameter int unsigned STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              press_i,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] TOP = STEP_W'(STEPS);

  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      step_q <= '0;
    else if (press_i) step_q <= (step_q == TOP) ? '0 : step_q + 1'b1;
  end

  assign step_o = step_q;

  // R4
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= TOP);

  // R2
  step_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !press_i |=> $stable(step_q));

  // R2
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_i && (step_q != TOP) |=> step_q == $past(step_q) + 1'b1);

  // R3
  step_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_i && (step_q == TOP) |=> step_q == '0);
endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = &cnt_q;

  // R5
  period_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_o == '0);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned STEPS  = 10,
  parameter int unsigned STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              pwm_o
);
  localparam int unsigned CMP_W = CNT_W + 1;
  localparam int unsigned LUT_N = 2 ** STEP_W;

  logic [CMP_W-1:0] lut [LUT_N];
  logic [CMP_W-1:0] act_q;
  logic [CMP_W-1:0] cmp_nxt;

  for (genvar i = 0; i < LUT_N; i++) begin : g_lut
    localparam int unsigned SI = (i > STEPS) ? STEPS : i;
    assign lut[i] = CMP_W'(pwm_step_pkg::step_to_cmp(SI, STEPS, CNT_W));
  end

  assign cmp_nxt = lut[step_i];

  // shadow compare: reload only at period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (wrap_i) act_q <= cmp_nxt;
  end

  assign pwm_o = {1'b0, cnt_i} < act_q;

  // R10
  cmp_shadow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(act_q));

  // R5
  rise_at_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i && (cmp_nxt != '0) |=> pwm_o);

  // R6
  low_until_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_o && !wrap_i |=> !pwm_o);
endmodule

// File: rtl/pwm_step_bank.sv
module pwm_step_bank #(
  parameter int unsigned N_CH    = 4,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned STEPS   = 10,
  parameter int unsigned DEB_CNT = 8,
  localparam int unsigned STEP_W = $clog2(STEPS + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_CH-1:0]          btn_i,
  output logic [N_CH-1:0]          pwm_o,
  output logic [N_CH*STEP_W-1:0]   duty_o
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  period_counter #(.CNT_W(CNT_W)) u_period (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic              press;
    logic [STEP_W-1:0] step;

    btn_conditioner #(.DEB_CNT(DEB_CNT)) u_btn (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .btn_i  (btn_i[g]),
      .press_o(press)
    );

    duty_stepper #(.STEPS(STEPS), .STEP_W(STEP_W)) u_step (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .press_i(press),
      .step_o (step)
    );

    pwm_channel #(.CNT_W(CNT_W), .STEPS(STEPS), .STEP_W(STEP_W)) u_pwm (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cnt_i (cnt),
      .wrap_i(wrap),
      .step_i(step),
      .pwm_o (pwm_o[g])
    );

    assign duty_o[g*STEP_W +: STEP_W] = step;
  end
endmodule

// File: tb/tb_pwm_step_bank.sv
`timescale 1ns/1ps
module tb_pwm_step_bank;
  localparam int DEB = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  btn_i = '0;
  logic [3:0]  pwm_o;
  logic [15:0] duty_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit mon_en = 0;
  int model[4] = '{0, 0, 0, 0};
  int last[4] = '{0, 0, 0, 0};
  int exp_ch[$];
  int exp_step[$];
  int hc[4];
  // R4 table
  int exp_cmp[11] = '{0, 26, 51, 77, 102, 128, 154, 179, 205, 230, 256};

  always #2.5 clk = ~clk;

  pwm_step_bank #(.DEB_CNT(DEB)) dut (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .btn_i (btn_i),
    .pwm_o (pwm_o),
    .duty_o(duty_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: push expected step then press
  task automatic press(int ch, int hold = DEB + 12);
    model[ch] = (model[ch] == 10) ? 0 : model[ch] + 1;
    exp_ch.push_back(ch);
    exp_step.push_back(model[ch]);
    btn_i[ch] = 1'b1;
    repeat (hold) @(negedge clk);
    btn_i[ch] = 1'b0;
    repeat (DEB + 12) @(negedge clk);
  endtask

  // monitor: every step change must match the next queued item (R2, R3, R9)
  always @(negedge clk) begin
    if (mon_en) begin
      for (int k = 0; k < 4; k++) begin
        int cur;
        cur = int'(duty_o[k*4 +: 4]);
        if (cur != last[k]) begin
          if (exp_ch.size() == 0) begin
            chk(0, "R2/R8 unexpected step change", cur, last[k]);
          end else begin
            int ech, est;
            ech = exp_ch.pop_front();
            est = exp_step.pop_front();
            chk(ech == k && est == cur, "R2/R3 step change", k * 100 + cur, ech * 100 + est);
          end
          last[k] = cur;
        end
      end
    end
  end

  task automatic measure();
    for (int k = 0; k < 4; k++) hc[k] = 0;
    repeat (256) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) if (pwm_o[k]) hc[k]++;
    end
  endtask

  task automatic check_all(string req);
    repeat (300) @(negedge clk);
    measure();
    for (int k = 0; k < 4; k++) chk(hc[k] == exp_cmp[model[k]], req, hc[k], exp_cmp[model[k]]);
  endtask

  // complete high runs on a channel must have width a or b (R10)
  task automatic watch_runs(int ch, int a, int b, int ncyc);
    int len = 0;
    bit seen_rise = 0;
    bit prev = pwm_o[ch];
    int runs = 0;
    repeat (ncyc) begin
      @(negedge clk);
      if (pwm_o[ch] && !prev) begin
        seen_rise = 1;
        len = 0;
      end
      if (pwm_o[ch]) len++;
      if (!pwm_o[ch] && prev && seen_rise) begin
        runs++;
        chk(len == a || len == b, "R10 high run width", len, b);
      end
      prev = pwm_o[ch];
    end
    chk(runs >= 3, "R10 runs observed", runs, 3);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    mon_en = 1;
    @(negedge clk);
    // R1 reset state
    chk(duty_o == 16'h0, "R1 reset duty", int'(duty_o), 0);
    chk(pwm_o == 4'h0, "R1 reset pwm", int'(pwm_o), 0);
    check_all("R7 zero compare low");

    // R2 independent channels, R4/R5/R6/R7 widths
    repeat (5) press(0);
    press(1);
    repeat (10) press(3);
    check_all("R4/R6 high count per period");
    chk(int'(duty_o[15:12]) == 10, "R7 full step index", int'(duty_o[15:12]), 10);

    // R3 wrap at full scale
    press(3);
    chk(int'(duty_o[15:12]) == 0, "R3 wrap to zero", int'(duty_o[15:12]), 0);
    check_all("R3 wrapped channel output");

    // R8 bounce bursts shorter than DEB_CNT give nothing
    repeat (4) begin
      btn_i[2] = 1'b1;
      repeat (3) @(negedge clk);
      btn_i[2] = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    chk(int'(duty_o[11:8]) == 0, "R8 bounce ignored", int'(duty_o[11:8]), 0);
    measure();
    chk(hc[2] == 0, "R8 bounce no pwm", hc[2], 0);

    // R9 long hold gives exactly one step
    press(1, 600);
    chk(int'(duty_o[7:4]) == 2, "R9 long hold one step", int'(duty_o[7:4]), 2);
    check_all("R9 after long hold");

    // R10 press just after a falling edge of channel 0 (128 -> 154)
    fork
      watch_runs(0, 128, 154, 1400);
      begin
        @(negedge clk);
        while (!pwm_o[0]) @(negedge clk);
        while (pwm_o[0]) @(negedge clk);
        press(0);
      end
    join
    check_all("R10 new width after wrap");

    repeat (3) press(0);
    check_all("R4 step 9 width");

    repeat (20) @(negedge clk);
    chk(exp_ch.size() == 0, "R2 all presses seen", exp_ch.size(), 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule